// File: doc/BRIEF.md
# Early-Ending Memory Write Strobe Generator

This block is synchronous glue logic placed between a two-T-state processor bus and writable RAM or I/O targets. The processor removes its write data at the same instant its own write line goes away, so memories see no data hold time. The block follows every bus cycle from the address strobe to the terminating edge and drives its own active-low write enables. These enables end one clock period before that terminating edge, while the address and data are still valid.

The logic runs on a clock at twice the processor rate, so each T-state spans two clock periods: an early phase and a late phase. A cycle with no waits has two T-states, T1 and T2. Each wait state adds one more T2-like T-state. The number of waits is never known in advance. In the early phase of every T2 or wait T-state the block samples the active ready signal, and when ready is active it knows that T-state is the last one. Ready comes from one of two sources, chosen by an indicator input: the processor's own ready pin while the on-chip wait generator drives it, or the external ready line otherwise.

States: `ST_IDLE` (no cycle), `ST_T1_LATE` (late phase of T1), `ST_T2_EARLY` (early phase of T2 or of a wait T-state), `ST_T2_HOLD` (late phase of a T-state that is not the last), `ST_T2_LAST` (late phase of the final T-state). Transitions: IDLE→T1_LATE when the address strobe is sampled low. T1_LATE→T2_EARLY always. T2_EARLY→T2_LAST when ready is active, otherwise T2_EARLY→T2_HOLD. T2_HOLD→T2_EARLY always. T2_LAST→IDLE always, at the terminating edge.

Top module: `ews_write_strobe`

## Requirements
- R1: In ST_IDLE, an address strobe (`cyc_start_n`) sampled low at a rising edge starts a cycle in ST_T1_LATE and latches `dir_wr` (1 = write) and `tgt_sel`; all enables stay high for that period.
- R2: On a write cycle, the enable of each selected target (`tgt_sel[0]`/`we_n[0]` = RAM, `tgt_sel[1]`/`we_n[1]` = I/O) goes low at the edge that enters the first T2 early phase, one edge after the start sample; unselected targets stay high.
- R3: While ready is sampled inactive (high) in a T2 early phase, the enable stays low through that T-state and the next wait T-state.
- R4: Ready sampled active (low) in a T2 early phase raises the enable at the next edge, one clock period before the terminating edge, and the block returns to ST_IDLE at the terminating edge.
- R5: With `rdy_src_int` = 1 only `rdy_obs_n` is used as ready; with `rdy_src_int` = 0 only `rdy_ext_n` is used; the other line has no effect.
- R6: Read cycles (`dir_wr` = 0) never drive any enable low.
- R7: Ready seen during the late phase of T1 or during the late phase of a T-state has no effect on the enable or on the cycle length.
- R8: An address strobe in the clock period right after a terminating edge starts a new cycle with no idle gap.
- R9: Synchronous active-high `rst` forces ST_IDLE with every enable high at the next edge, even in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the processor rate |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start_n | input | 1 | Address strobe, active low |
| dir_wr | input | 1 | Cycle direction, 1 = write |
| tgt_sel | input | TGT_W | Writable target selects, bit0 RAM, bit1 I/O |
| rdy_src_int | input | 1 | 1 = on-chip wait generator drives ready |
| rdy_obs_n | input | 1 | Observed processor ready pin, active low |
| rdy_ext_n | input | 1 | External ready line, active low |
| we_n | output | TGT_W | Active-low write enables, bit0 RAM, bit1 I/O |

## Verification
On every cycle, the embedded properties check the state sequence around the start sample and the terminating edge. They also check that enables stay high in idle and on read cycles, that a ready sampled in the early phase lifts the enable at the next edge and that a missing ready keeps it low, and that reset clears everything. Only the bench scenarios can show the complete strobe shape over whole cycles with zero, one and several waits. The same holds for ignoring the unselected ready source and ready seen outside early phases, for back-to-back cycles with no gap, and for a reset that arrives in the middle of a write.

// File: rtl/ews_pkg.sv
package ews_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_T1_LATE  = 3'd1,
        ST_T2_EARLY = 3'd2,
        ST_T2_HOLD  = 3'd3,
        ST_T2_LAST  = 3'd4
    } ews_state_e;
endpackage

// File: rtl/ews_ready_sel.sv
module ews_ready_sel (
    input  logic rdy_src_int,
    input  logic rdy_obs_n,
    input  logic rdy_ext_n,
    output logic rdy_act
);
    // Pick the line that currently carries ready; active low on the pins.
    always_comb begin
        if (rdy_src_int) rdy_act = ~rdy_obs_n;
        else             rdy_act = ~rdy_ext_n;
    end
endmodule

// File: rtl/ews_cycle_fsm.sv
module ews_cycle_fsm
    import ews_pkg::*;
#(
    parameter int TGT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start_n,
    input  logic             dir_wr,
    input  logic [TGT_W-1:0] tgt_sel,
    input  logic             rdy_act,
    output ews_state_e       st,
    output ews_state_e       st_nxt,
    output logic             wr_q,
    output logic [TGT_W-1:0] sel_q
);
    logic start_hit;
    assign start_hit = (st == ST_IDLE) && !cyc_start_n;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:     st_nxt = start_hit ? ST_T1_LATE : ST_IDLE;
            ST_T1_LATE:  st_nxt = ST_T2_EARLY;
            ST_T2_EARLY: st_nxt = rdy_act ? ST_T2_LAST : ST_T2_HOLD;
            ST_T2_HOLD:  st_nxt = ST_T2_EARLY;
            ST_T2_LAST:  st_nxt = ST_IDLE;
            default:     st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            wr_q  <= 1'b0;
            sel_q <= '0;
        end else begin
            st <= st_nxt;
            if (start_hit) begin
                wr_q  <= dir_wr;
                sel_q <= tgt_sel;
            end
        end
    end

    // R1
    start_to_t1_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !cyc_start_n) |=> (st == ST_T1_LATE));
    // R4
    last_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T2_LAST) |=> (st == ST_IDLE));
    // R7
    t1_ignores_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T1_LATE) |=> (st == ST_T2_EARLY));
endmodule

// File: rtl/ews_strobe_out.sv
module ews_strobe_out
    import ews_pkg::*;
#(
    parameter int TGT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  ews_state_e       st_nxt,
    input  logic             wr_q,
    input  logic [TGT_W-1:0] sel_q,
    output logic [TGT_W-1:0] we_n
);
    logic strobe_window;
    always_comb begin
        strobe_window = wr_q &&
            ((st_nxt == ST_T2_EARLY) || (st_nxt == ST_T2_HOLD));
    end

    for (genvar g = 0; g < TGT_W; g++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (rst) we_n[g] <= 1'b1;
            else     we_n[g] <= ~(strobe_window && sel_q[g]);
        end
    end
endmodule

// File: rtl/ews_write_strobe.sv
module ews_write_strobe
    import ews_pkg::*;
#(
    parameter int TGT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start_n,
    input  logic             dir_wr,
    input  logic [TGT_W-1:0] tgt_sel,
    input  logic             rdy_src_int,
    input  logic             rdy_obs_n,
    input  logic             rdy_ext_n,
    output logic [TGT_W-1:0] we_n
);
    ews_state_e       st, st_nxt;
    logic             rdy_act, wr_q;
    logic [TGT_W-1:0] sel_q;

    ews_ready_sel u_rdy (
        .rdy_src_int (rdy_src_int),
        .rdy_obs_n   (rdy_obs_n),
        .rdy_ext_n   (rdy_ext_n),
        .rdy_act     (rdy_act)
    );

    ews_cycle_fsm #(.TGT_W(TGT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cyc_start_n (cyc_start_n),
        .dir_wr      (dir_wr),
        .tgt_sel     (tgt_sel),
        .rdy_act     (rdy_act),
        .st          (st),
        .st_nxt      (st_nxt),
        .wr_q        (wr_q),
        .sel_q       (sel_q)
    );

    ews_strobe_out #(.TGT_W(TGT_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .st_nxt (st_nxt),
        .wr_q   (wr_q),
        .sel_q  (sel_q),
        .we_n   (we_n)
    );

    // R6
    read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && !wr_q) |=> (&we_n));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |=> (&we_n));
    // R4
    early_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T2_EARLY && rdy_act) |=> (&we_n));
    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_T2_EARLY && !rdy_act && wr_q && sel_q[0]) |=> !we_n[0]);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (&we_n && st == ST_IDLE));
endmodule

// File: tb/ews_write_strobe_tb.sv
module ews_write_strobe_tb;
    localparam int TGT_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cyc_start_n = 1'b1;
    logic             dir_wr = 1'b0;
    logic [TGT_W-1:0] tgt_sel = '0;
    logic             rdy_src_int = 1'b1;
    logic             rdy_obs_n = 1'b1;
    logic             rdy_ext_n = 1'b1;
    logic [TGT_W-1:0] we_n;

    int checks = 0;
    int fails  = 0;
    int cyc_cnt = 0;
    logic [TGT_W-1:0] exp_q[$];
    string            tag_q[$];

    always #4 clk = ~clk;

    ews_write_strobe #(.TGT_W(TGT_W)) u_dut (
        .clk(clk), .rst(rst), .cyc_start_n(cyc_start_n), .dir_wr(dir_wr),
        .tgt_sel(tgt_sel), .rdy_src_int(rdy_src_int), .rdy_obs_n(rdy_obs_n),
        .rdy_ext_n(rdy_ext_n), .we_n(we_n)
    );

    // Monitor: compares each edge's result with the scoreboard head.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [TGT_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (we_n !== e) begin
                fails++;
                $display("FAIL %s we_n actual=%b expected=%b at %0t", t, we_n, e, $time);
            end
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic push(input logic [TGT_W-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // Drive the chosen ready source; hold the other active to prove it is ignored (R5).
    task automatic set_rdy(input bit use_int, input logic v);
        rdy_src_int = use_int;
        if (use_int) begin rdy_obs_n = v; rdy_ext_n = 1'b0; end
        else         begin rdy_ext_n = v; rdy_obs_n = 1'b0; end
    endtask

    task automatic idle_step(input string t);
        @(negedge clk);
        cyc_start_n = 1'b1;
        push('1, t);
    endtask

    task automatic run_cycle(input bit wr, input logic [TGT_W-1:0] sel,
                             input bit use_int, input int waits,
                             input bit noisy, input string t);
        logic [TGT_W-1:0] act;
        act = wr ? ~sel : '1;
        @(negedge clk);
        cyc_start_n = 1'b0; dir_wr = wr; tgt_sel = sel;
        set_rdy(use_int, 1'b1);
        push('1, {t, "/R1"});
        @(negedge clk);
        cyc_start_n = 1'b1; dir_wr = ~wr; tgt_sel = ~sel;
        set_rdy(use_int, noisy ? 1'b0 : 1'b1);        // R7: ready in T1 late phase
        push(act, {t, "/R2"});
        for (int i = 0; i <= waits; i++) begin
            @(negedge clk);
            set_rdy(use_int, (i == waits) ? 1'b0 : 1'b1);
            push((i < waits) ? act : '1, (i < waits) ? {t, "/R3"} : {t, "/R4"});
            @(negedge clk);
            set_rdy(use_int, (noisy && i < waits) ? 1'b0 : 1'b1); // R7: late phase
            push((i < waits) ? act : '1, (i < waits) ? {t, "/R3"} : {t, "/R4"});
        end
    endtask

    initial begin
        // R9: reset state
        @(negedge clk); push('1, "R9");
        @(negedge clk); push('1, "R9");
        rst = 1'b0;
        idle_step("R1");
        run_cycle(1'b1, 2'b01, 1'b1, 0, 1'b0, "R2");
        idle_step("R4");
        run_cycle(1'b1, 2'b10, 1'b0, 2, 1'b0, "R5");
        run_cycle(1'b1, 2'b01, 1'b1, 3, 1'b0, "R3");
        idle_step("R4");
        run_cycle(1'b0, 2'b01, 1'b1, 1, 1'b0, "R6");
        run_cycle(1'b0, 2'b10, 1'b0, 0, 1'b0, "R6");
        // R8: back-to-back cycles with no idle period between
        run_cycle(1'b1, 2'b01, 1'b1, 1, 1'b0, "R8");
        run_cycle(1'b1, 2'b10, 1'b1, 0, 1'b0, "R8");
        run_cycle(1'b1, 2'b01, 1'b0, 1, 1'b0, "R8");
        idle_step("R8");
        run_cycle(1'b1, 2'b01, 1'b1, 2, 1'b1, "R7");
        run_cycle(1'b1, 2'b10, 1'b0, 1, 1'b1, "R7");
        run_cycle(1'b1, 2'b00, 1'b1, 1, 1'b0, "R2");
        run_cycle(1'b1, 2'b11, 1'b1, 1, 1'b0, "R2");
        // R9: reset in the middle of a write
        @(negedge clk);
        cyc_start_n = 1'b0; dir_wr = 1'b1; tgt_sel = 2'b01; set_rdy(1'b1, 1'b1);
        push('1, "R9/R1");
        @(negedge clk);
        cyc_start_n = 1'b1;
        push(2'b10, "R9/R2");
        @(negedge clk);
        rst = 1'b1;
        push('1, "R9");
        @(negedge clk);
        rst = 1'b0;
        push('1, "R9");
        idle_step("R9");
        run_cycle(1'b1, 2'b10, 1'b1, 0, 1'b0, "R9");
        repeat (4) idle_step("R1");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 scoreboard left=%0d expected=0", exp_q.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule